// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a bank of read-only configuration bytes once, straight after reset. When its strap input is high, it clocks a read command for each byte address out to a serial EEPROM, starting at address zero and counting up. It captures the byte that comes back and writes it into the register with the same index. When the strap is low, no EEPROM is fitted. The bank is then filled with computed default values and the serial lines stay idle.

Each read keeps the chip select high for the whole command. The command is a start bit of one, the opcode bits one then zero, and the byte address most significant bit first. The EEPROM answers with a zero dummy bit and then eight data bits, most significant bit first. The serial clock is the system clock divided by a parameter. Reads are separated by at least one full serial clock period with the select low.

A done flag tells the host side that the bank is valid. Until it is set, the read port returns zero.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held and in the first cycle after it is released, ee_cs, ee_sclk and cfg_done are low and rd_data is zero.
- R2: With ee_en high when reset is released, exactly NBYTES reads are issued, with addresses 0 to NBYTES-1 in ascending order. Each read drives on ee_sdo a 1 start bit, then opcode bits 1 and 0, then the address (clog2(NBYTES) bits), most significant bit first.
- R3: In each read, the bit clocked after the address is a dummy bit and is ignored. The following eight bits, most significant first, are stored as the register of that read's address.
- R4: ee_sclk has a period of CLK_DIV system clocks and is high for the second half, CLK_DIV/2 cycles. ee_sdi is sampled at the rising edge of ee_sclk. ee_sclk is low when ee_cs rises.
- R5: ee_sclk only toggles while ee_cs is high. ee_cs stays low for at least CLK_DIV system clocks before every rise.
- R6: With ee_en low when reset is released, ee_cs never rises. Register i receives DEF_KEY XOR ((i*29) mod 256), and cfg_done rises within NBYTES+3 cycles.
- R7: cfg_done rises only after the last register has been written and stays high until reset. While cfg_done is low, rd_data is zero. Once it is set, rd_data is the register selected by rd_addr.
- R8: The load runs once per reset. After cfg_done, ee_cs stays low, and changes of ee_en after the first cycle after reset have no effect.
- R9: A reset during a load abandons it. The next load restarts at address 0 and completes with the full image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_en | input | 1 | Strap: 1 loads from EEPROM, 0 loads defaults |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sclk | output | 1 | EEPROM serial clock |
| ee_sdo | output | 1 | Command bits to the EEPROM |
| ee_sdi | input | 1 | Data bits from the EEPROM |
| rd_addr | input | clog2(NBYTES) | Register index for the host read port |
| rd_data | output | 8 | Selected register, zero before done |
| cfg_done | output | 1 | Configuration bank valid |

## Verification
The bench builds the loader with CLK_DIV=8, NBYTES=64 and DEF_KEY=8'h3C. The short divider makes several full 64-byte loads fit in one run, together with a default fill and a load cut short by reset. At the same time, the full address width and the last-register boundary are still exercised. The divider of 8 still gives a four-cycle high phase, so off-by-one errors in the sampling point and in the select gap show up as wrong data or wrong measured intervals.

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader #(
  parameter int NBYTES = 64,
  parameter int CLK_DIV = 64,
  parameter logic [7:0] DEF_KEY = 8'h3C,
  localparam int AW = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ee_en,
  output logic          ee_cs,
  output logic          ee_sclk,
  output logic          ee_sdo,
  input  logic          ee_sdi,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          cfg_done
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW = $clog2(CLK_DIV);
  localparam int CMDW = 3 + AW;
  localparam int TOT = CMDW + 9;
  localparam int BW = $clog2(TOT + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEF, S_GAP, S_SHIFT, S_DONE} st_t;

  st_t             st;
  logic [DW-1:0]   div;
  logic [BW-1:0]   bitn;
  logic [AW-1:0]   idx;
  logic [CMDW-1:0] cmd;
  logic [7:0]      shreg;
  logic [7:0]      regs [NBYTES];

  function automatic logic [7:0] defb(input logic [AW-1:0] a);
    logic [15:0] p;
    p = 16'(a) * 16'd29;
    return DEF_KEY ^ p[7:0];
  endfunction

  wire last_byte = (idx == AW'(NBYTES - 1));
  wire end_bit   = (div == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      div   <= '0;
      bitn  <= '0;
      idx   <= '0;
      cmd   <= '0;
      shreg <= '0;
      for (int i = 0; i < NBYTES; i++) regs[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          idx <= '0;
          div <= '0;
          st  <= ee_en ? S_GAP : S_DEF;
        end
        S_DEF: begin
          regs[idx] <= defb(idx);
          if (last_byte) st <= S_DONE;
          else idx <= idx + 1'b1;
        end
        S_GAP: begin
          if (end_bit) begin
            div  <= '0;
            bitn <= '0;
            cmd  <= {3'b110, idx};
            st   <= S_SHIFT;
          end else div <= div + 1'b1;
        end
        S_SHIFT: begin
          if (div == DW'(HALF - 1) && bitn > BW'(CMDW))
            shreg <= {shreg[6:0], ee_sdi};
          if (end_bit) begin
            div  <= '0;
            bitn <= bitn + 1'b1;
            cmd  <= {cmd[CMDW-2:0], 1'b0};
            if (bitn == BW'(TOT - 1)) begin
              regs[idx] <= shreg;
              if (last_byte) st <= S_DONE;
              else begin
                idx <= idx + 1'b1;
                st  <= S_GAP;
              end
            end
          end else div <= div + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ee_cs    = (st == S_SHIFT);
  assign ee_sclk  = ee_cs && (div >= DW'(HALF));
  assign ee_sdo   = ee_cs && (bitn < BW'(CMDW)) && cmd[CMDW-1];
  assign cfg_done = (st == S_DONE);
  assign rd_data  = cfg_done ? regs[rd_addr] : 8'h00;
endmodule

module cfg_eeprom_loader_chk #(
  parameter int CLK_DIV = 64
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sclk,
  input logic done
);
  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (cs) gap_q <= '0;
    else if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
  end

  p_sclk_inside_cs_r5: assert property (@(posedge clk) disable iff (!rst_n) !cs |-> !sclk);
  p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs) |-> (gap_q >= 16'(CLK_DIV)));
  p_sclk_low_at_select_r4: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs) |-> !sclk);
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> done);
  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n) done |-> !cs);
endmodule

bind cfg_eeprom_loader cfg_eeprom_loader_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(ee_cs), .sclk(ee_sclk), .done(cfg_done)
);

// File: tb/test_cfg_eeprom_loader.sv
module test_cfg_eeprom_loader;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 64;
  localparam int DIV = 8;
  localparam logic [7:0] KEY = 8'h3C;
  localparam int AW = $clog2(NB);
  localparam int CMDW = 3 + AW;
  localparam int TOT = CMDW + 9;

  logic clk = 0, rst_n = 0, ee_en = 1, ee_sdi = 1;
  logic ee_cs, ee_sclk, ee_sdo, cfg_done;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;

  cfg_eeprom_loader #(.NBYTES(NB), .CLK_DIV(DIV), .DEF_KEY(KEY)) i_cfg_eeprom_loader (
    .clk(clk), .rst_n(rst_n), .ee_en(ee_en), .ee_cs(ee_cs), .ee_sclk(ee_sclk),
    .ee_sdo(ee_sdo), .ee_sdi(ee_sdi), .rd_addr(rd_addr), .rd_data(rd_data), .cfg_done(cfg_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] mem [NB];
  int c = 0, exp_addr = 0, nreads = 0, addr = 0;
  logic [CMDW-1:0] cmd_in = '0;
  int per_err = 0, high_err = 0, gap_err = 0, cs_rises = 0;
  int since_rise = 0, high_run = 0, low_run = 0;
  bit first_in_burst = 0, prev_sclk = 0, prev_cs = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] def_byte(input int i);
    return KEY ^ 8'((i * 29) % 256);
  endfunction

  always @(posedge ee_cs) begin c = 0; cmd_in = '0; end
  always @(posedge ee_sclk) if (ee_cs) begin
    if (c < CMDW) cmd_in = {cmd_in[CMDW-2:0], ee_sdo};
    c++;
    if (c == CMDW) addr = int'(cmd_in[AW-1:0]);
  end
  always @(negedge ee_sclk) if (ee_cs) begin
    if (c == CMDW) ee_sdi = 1'b0;
    else if (c > CMDW && c <= CMDW + 8)
      ee_sdi = (cmd_in[CMDW-1 -: 3] == 3'b110) ? mem[addr][7-(c-CMDW-1)] : 1'b1;
  end
  always @(negedge ee_cs) begin
    ee_sdi = 1'b1;
    if (rst_n) begin
      chk(cmd_in == {3'b110, AW'(exp_addr)}, "R2 command/address", int'(cmd_in), int'({3'b110, AW'(exp_addr)}));
      chk(c == TOT, "R2 clocks per read", c, TOT);
      exp_addr++;
      nreads++;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      since_rise = 0; high_run = 0; low_run = 0; prev_sclk = 0; prev_cs = 0;
    end else begin
      since_rise++;
      if (ee_cs && !prev_cs) begin
        cs_rises++;
        if (low_run < DIV) gap_err++;
        if (ee_sclk) per_err++;
        first_in_burst = 1;
      end
      if (!ee_cs && ee_sclk) gap_err++;
      if (ee_sclk && !prev_sclk) begin
        if (!first_in_burst && since_rise != DIV) per_err++;
        first_in_burst = 0;
        since_rise = 0;
      end
      if (!ee_sclk && prev_sclk && high_run != DIV/2) high_err++;
      high_run = ee_sclk ? high_run + 1 : 0;
      low_run = ee_cs ? 0 : low_run + 1;
      prev_sclk = ee_sclk;
      prev_cs = ee_cs;
    end
  end

  always @(posedge clk) if (cycles > 190000) begin
    chk(0, "watchdog", cycles, 190000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic do_reset(input bit en);
    rst_n = 0;
    ee_en = en;
    repeat (3) @(posedge clk);
    exp_addr = 0; nreads = 0; cs_rises = 0;
    per_err = 0; high_err = 0; gap_err = 0;
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(!ee_cs && !ee_sclk && !cfg_done && rd_data == 8'h00, "R1 reset state",
        int'({ee_cs, ee_sclk, cfg_done}), 0);
  endtask

  task automatic wait_done(input int limit, output int n);
    n = 0;
    while (!cfg_done && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic check_image(input bit defaults, input string req);
    int errs = 0, first_bad = -1;
    for (int i = 0; i < NB; i++) begin
      rd_addr = AW'(i);
      #1;
      if (rd_data != (defaults ? def_byte(i) : mem[i])) begin
        errs++;
        if (first_bad < 0) first_bad = i;
      end
    end
    chk(errs == 0, req, errs, 0);
    if (first_bad >= 0) $display("  first mismatch at register %0d", first_bad);
  endtask

  task automatic full_load(input string tag);
    int n;
    wait_done(NB * (TOT + 1) * DIV + 50, n);
    chk(cfg_done, {"R7 done after load ", tag}, int'(cfg_done), 1);
    chk(nreads == NB, {"R2 read count ", tag}, nreads, NB);
    check_image(0, {"R3 stored image ", tag});
    chk(per_err == 0 && high_err == 0, {"R4 sclk period/high ", tag}, per_err + high_err, 0);
    chk(gap_err == 0, {"R5 select gap ", tag}, gap_err, 0);
  endtask

  initial begin
    int n, stop_at;
    void'($urandom(32'd4242));

    for (int i = 0; i < NB; i++) mem[i] = 8'($urandom);
    do_reset(1);
    while (nreads < 10) @(negedge clk);
    rd_addr = '0; #1;
    chk(rd_data == 8'h00 && !cfg_done, "R7 read gated during load", rd_data, 0);
    full_load("random");
    n = cs_rises;
    ee_en = 0;
    repeat (5 * DIV) @(negedge clk);
    ee_en = 1;
    repeat (5 * DIV) @(negedge clk);
    chk(cs_rises == n && cfg_done, "R8 no reload after done", cs_rises, n);
    check_image(0, "R8 image unchanged by strap");

    for (int i = 0; i < NB; i++) mem[i] = i[0] ? 8'h80 : 8'h01;
    mem[0] = 8'h00;
    mem[NB-1] = 8'hFF;
    do_reset(1);
    full_load("edge patterns");

    for (int i = 0; i < NB; i++) mem[i] = 8'($urandom);
    do_reset(0);
    @(negedge clk) ee_en = 1;
    wait_done(NB + 3, n);
    chk(cfg_done, "R6 default fill time", n, NB + 3);
    chk(cs_rises == 0, "R6 no select when disabled", cs_rises, 0);
    check_image(1, "R6 default values");
    chk(cs_rises == 0, "R8 late strap ignored", cs_rises, 0);

    for (int i = 0; i < NB; i++) mem[i] = 8'($urandom);
    do_reset(1);
    stop_at = int'($urandom_range(3, 20));
    while (nreads < stop_at) @(negedge clk);
    repeat (int'($urandom_range(0, TOT * DIV))) @(negedge clk);
    for (int i = 0; i < NB; i++) mem[i] = 8'($urandom);
    do_reset(1);
    full_load("after reset mid-load R9");
    chk(exp_addr == NB, "R9 restart from address 0", exp_addr, NB);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule